// File: doc/BRIEF.md
# Configuration Port Bridge

This block gives a host processor indirect access to a bank of 32-bit configuration registers through two I/O locations. The first location is an index latch: software writes a dword there to choose a register and to arm writes. The second is a four-byte data window at the next dword. Every byte address in the window can be read or written, and its low two address bits select the byte lane where the access starts.

Reads through the window return the selected register shifted down to the starting lane and masked to the access width. Writes are merged into the register byte by byte. A write goes through only if the arm bit of the latch is set and the size and offset form one of the allowed pairs. Reads do not depend on the arm bit. An access to any I/O address the block does not decode raises an error flag, and a read there returns all ones. Read data is registered and appears one cycle after the request.

Top module: `cfg_port_bridge`

## Requirements
- R1: A write of any size to the latch port (0xCF8) loads the latch. Bit 31 of the written dword is the write arm bit, and bits 7:2 select one of 64 registers. Bits 30:8 and 1:0 have no effect on later accesses.
- R2: A data-window access (0xCFC to 0xCFF) always addresses the register selected by latch bits 7:2, whatever the window byte address.
- R3: A window write changes nothing while latch bit 31 is clear. Window reads return register contents whether bit 31 is set or clear.
- R4: A window write at byte offset k (address bits 1:0) with size s bytes replaces register bytes k to k+s-1 with write-data bytes 0 to s-1. All other register bytes keep their values.
- R5: The only allowed writes are sizes 1, 2 or 4 at offset 0, sizes 1 or 2 at offsets 1 and 2, and size 1 at offset 3. Every other size and offset pair, including sizes 0, 3, 5, 6 and 7, leaves the register unchanged.
- R6: A window read at offset k returns the register shifted right by 8k bits. The result is masked to 8 bits for size 1 and to 16 bits for size 2. Any other size returns all 32 shifted bits.
- R7: After reset, all 64 registers read as zero, the latch is clear, and rd_valid and acc_err are low.
- R8: Each read request is followed one cycle later by a single-cycle rd_valid pulse. rd_valid stays low after writes and idle cycles.
- R9: A request to an address outside the latch port and the data window, or a read of the latch port, sets acc_err in the next cycle, and a read of this kind returns 0xFFFFFFFF. Window accesses and latch writes leave acc_err low.
- R10: Inputs applied while req_valid is low change no register and no latch state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 16 | I/O byte address |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 are meaningful) |
| req_wdata | input | 32 | Write data, least significant byte first |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| acc_err | output | 1 | Undecoded access flag, one cycle after the request |

## Verification
The bound assertions check the following on every cycle: the one-cycle read timing and the absence of spurious valid pulses, the error flag and the all-ones data for undecoded reads, the zero upper bits of byte-wide reads and of reads at offset 3, and the quiet outputs after reset. The assertions cannot see register contents. Lane merging, the arm-bit gate, the table of allowed size and offset pairs, and the independence from the latch don't-care bits are therefore shown only by the bench. It sweeps every register against every offset and every size code and compares each read against an arithmetic model.

// File: rtl/cfg_port_pkg.sv
// Package: shared constants and types for the configuration port bridge.
// Assumes the data window starts on a dword boundary.
package cfg_port_pkg;
    localparam int unsigned DWORD_W = 32;
    localparam int unsigned LANES   = DWORD_W / 8;
    localparam int unsigned ARM_BIT = 31;

    // Kind of I/O location a request targets.
    typedef enum logic [1:0] {
        PK_NONE  = 2'd0,
        PK_LATCH = 2'd1,
        PK_DATA  = 2'd2
    } port_kind_e;
endpackage

// File: rtl/cfg_port_decode.sv
// Module: cfg_port_decode
// Classifies a request by address, derives the byte offset inside the data
// window, decides the byte lanes a write may touch from an explicit table of
// allowed size/offset pairs, and steers write bytes onto their lanes.
// Purely combinational. Assumes DATA_PORT is dword aligned.
module cfg_port_decode
    import cfg_port_pkg::*;
#(
    parameter int          IO_AW      = 16,
    parameter int unsigned LATCH_PORT = 'hCF8,
    parameter int unsigned DATA_PORT  = 'hCFC
) (
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [IO_AW-1:0]   req_addr,
    input  logic [2:0]         req_size,
    input  logic [DWORD_W-1:0] req_wdata,
    output port_kind_e         kind,
    output logic [1:0]         lane_off,
    output logic [LANES-1:0]   wr_lanes,
    output logic [DWORD_W-1:0] wr_aligned,
    output logic               bad_access
);
    localparam logic [IO_AW-1:0] LATCH_A = LATCH_PORT[IO_AW-1:0];
    localparam logic [IO_AW-1:0] DATA_A  = DATA_PORT[IO_AW-1:0];

    // Purpose: classify the target location of the request.
    always_comb begin
        if (req_addr == LATCH_A)
            kind = PK_LATCH;
        else if (req_addr[IO_AW-1:2] == DATA_A[IO_AW-1:2])
            kind = PK_DATA;
        else
            kind = PK_NONE;
    end

    assign lane_off = req_addr[1:0];

    // Purpose: table of allowed size/offset pairs and the lanes each touches.
    always_comb begin
        unique case ({lane_off, req_size})
            {2'd0, 3'd1}: wr_lanes = 4'b0001;
            {2'd0, 3'd2}: wr_lanes = 4'b0011;
            {2'd0, 3'd4}: wr_lanes = 4'b1111;
            {2'd1, 3'd1}: wr_lanes = 4'b0010;
            {2'd1, 3'd2}: wr_lanes = 4'b0110;
            {2'd2, 3'd1}: wr_lanes = 4'b0100;
            {2'd2, 3'd2}: wr_lanes = 4'b1100;
            {2'd3, 3'd1}: wr_lanes = 4'b1000;
            default:      wr_lanes = 4'b0000;
        endcase
    end

    // Purpose: rotate write bytes so byte 0 lands on the starting lane.
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            logic [1:0] src;
            src = 2'(j) - lane_off;
            wr_aligned[8*j +: 8] = req_wdata[8*src +: 8];
        end
    end

    // Purpose: flag undecoded locations and reads of the write-only latch.
    always_comb begin
        bad_access = 1'b0;
        if (req_valid) begin
            if (kind == PK_NONE)
                bad_access = 1'b1;
            else if (kind == PK_LATCH && !req_write)
                bad_access = 1'b1;
        end
    end
endmodule

// File: rtl/cfg_addr_latch.sv
// Module: cfg_addr_latch
// Holds the part of the index latch that affects behaviour: the write arm
// bit and the register index. Other written bits are not stored, because no
// later access depends on them. Synchronous active-low reset clears it.
module cfg_addr_latch #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             arm_in,
    input  logic [IDX_W-1:0] idx_in,
    output logic             arm_q,
    output logic [IDX_W-1:0] idx_q
);
    // Purpose: capture arm bit and index on a latch-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
            idx_q <= '0;
        end else if (load) begin
            arm_q <= arm_in;
            idx_q <= idx_in;
        end
    end
endmodule

// File: rtl/cfg_reg_bank.sv
// Module: cfg_reg_bank
// NUM_REGS configuration dwords with per-byte write enables and an
// asynchronous read mux. Each register is one generated flop group, cleared
// by the synchronous active-low reset.
module cfg_reg_bank
    import cfg_port_pkg::*;
#(
    parameter int NUM_REGS = 64,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [LANES-1:0]   wr_lanes,
    input  logic [DWORD_W-1:0] wr_data,
    output logic [DWORD_W-1:0] rd_word
);
    logic [DWORD_W-1:0] words [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic [DWORD_W-1:0] word_q;
        logic               hit;

        assign hit = wr_en && (idx == IDX_W'(r));

        // Purpose: merge enabled byte lanes into this register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (hit) begin
                for (int b = 0; b < LANES; b++)
                    if (wr_lanes[b])
                        word_q[8*b +: 8] <= wr_data[8*b +: 8];
            end
        end

        assign words[r] = word_q;
    end

    assign rd_word = words[idx];
endmodule

// File: rtl/cfg_read_fmt.sv
// Module: cfg_read_fmt
// Shifts and masks the selected register for a window read and registers
// the response: data, a one-cycle valid and the error flag. Undecoded reads
// return all ones. Synchronous active-low reset clears all outputs.
module cfg_read_fmt
    import cfg_port_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [2:0]         req_size,
    input  logic [1:0]         lane_off,
    input  logic               bad_access,
    input  logic [DWORD_W-1:0] reg_word,
    output logic [DWORD_W-1:0] rd_data,
    output logic               rd_valid,
    output logic               acc_err
);
    logic [DWORD_W-1:0] shifted;
    logic [DWORD_W-1:0] size_mask;
    logic [DWORD_W-1:0] formatted;

    // Purpose: width mask chosen by access size; other sizes pass 32 bits.
    always_comb begin
        case (req_size)
            3'd1:    size_mask = 32'h0000_00FF;
            3'd2:    size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    end

    assign shifted   = reg_word >> {lane_off, 3'b000};
    assign formatted = shifted & size_mask;

    // Purpose: register the read response and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            acc_err  <= 1'b0;
        end else begin
            rd_valid <= req_valid && !req_write;
            acc_err  <= bad_access;
            if (req_valid && !req_write)
                rd_data <= bad_access ? '1 : formatted;
        end
    end
endmodule

// File: rtl/cfg_port_bridge.sv
// Module: cfg_port_bridge (top)
// Index latch at LATCH_PORT plus a four-byte data window at DATA_PORT
// giving access to NUM_REGS configuration dwords. Window writes need the
// latch arm bit and an allowed size/offset pair; reads are never gated.
// Assumes one request per cycle and NUM_REGS <= 64 (index in latch 7:2).
module cfg_port_bridge
    import cfg_port_pkg::*;
#(
    parameter int          IO_AW      = 16,
    parameter int          NUM_REGS   = 64,
    parameter int unsigned LATCH_PORT = 'hCF8,
    parameter int unsigned DATA_PORT  = 'hCFC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic         req_write,
    input  logic [15:0]  req_addr,
    input  logic [2:0]   req_size,
    input  logic [31:0]  req_wdata,
    output logic [31:0]  rd_data,
    output logic         rd_valid,
    output logic         acc_err
);
    localparam int IDX_W = $clog2(NUM_REGS);

    port_kind_e         kind;
    logic [1:0]         lane_off;
    logic [LANES-1:0]   wr_lanes;
    logic [DWORD_W-1:0] wr_aligned;
    logic               bad_access;
    logic               arm_q;
    logic [IDX_W-1:0]   idx_q;
    logic               latch_load;
    logic               bank_we;
    logic [DWORD_W-1:0] reg_word;

    cfg_port_decode #(
        .IO_AW(IO_AW), .LATCH_PORT(LATCH_PORT), .DATA_PORT(DATA_PORT)
    ) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr[IO_AW-1:0]),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .kind      (kind),
        .lane_off  (lane_off),
        .wr_lanes  (wr_lanes),
        .wr_aligned(wr_aligned),
        .bad_access(bad_access)
    );

    assign latch_load = req_valid && req_write && (kind == PK_LATCH);
    assign bank_we    = req_valid && req_write && (kind == PK_DATA) && arm_q;

    cfg_addr_latch #(.IDX_W(IDX_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (latch_load),
        .arm_in (req_wdata[ARM_BIT]),
        .idx_in (req_wdata[IDX_W+1:2]),
        .arm_q  (arm_q),
        .idx_q  (idx_q)
    );

    cfg_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_we),
        .idx     (idx_q),
        .wr_lanes(wr_lanes),
        .wr_data (wr_aligned),
        .rd_word (reg_word)
    );

    cfg_read_fmt u_rdfmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .lane_off  (lane_off),
        .bad_access(bad_access),
        .reg_word  (reg_word),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .acc_err   (acc_err)
    );
endmodule

// File: rtl/cfg_port_bridge_chk.sv
// Module: cfg_port_bridge_chk
// Port-level protocol checks for cfg_port_bridge, attached by bind.
module cfg_port_bridge_chk #(
    parameter int unsigned LATCH_PORT = 'hCF8,
    parameter int unsigned DATA_PORT  = 'hCFC
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [15:0] req_addr,
    input logic [2:0]  req_size,
    input logic [31:0] rd_data,
    input logic        rd_valid,
    input logic        acc_err
);
    logic in_window;
    logic in_known;
    logic rd_req;

    assign in_window = (req_addr[15:2] == DATA_PORT[15:2]);
    assign in_known  = in_window || (req_addr == LATCH_PORT[15:0]);
    assign rd_req    = req_valid && !req_write;

    assert_rd_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    assert_err_all_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && acc_err) |-> (rd_data == 32'hFFFF_FFFF));
    assert_foreign_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_known) |=> acc_err);
    assert_window_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_window) |=> !acc_err);
    assert_byte_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && in_window && req_size == 3'd1) |=> (rd_data[31:8] == 24'h0));
    assert_top_lane_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && in_window && req_addr[1:0] == 2'd3) |=> (rd_data[31:8] == 24'h0));
    assert_reset_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rd_valid && !acc_err));
endmodule

bind cfg_port_bridge cfg_port_bridge_chk #(
    .LATCH_PORT(LATCH_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_size (req_size),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .acc_err  (acc_err)
);

// File: tb/cfg_port_bridge_tb.sv
module cfg_port_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        acc_err;

    int checks = 0;
    int errors = 0;

    logic [31:0] model [64];
    logic        m_arm = 1'b0;
    int          m_idx = 0;

    always #10 clk = ~clk;

    cfg_port_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .acc_err(acc_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // One request, driven at a falling edge; outputs are valid on return.
    task automatic access(input logic wr, input logic [15:0] a,
                          input logic [2:0] sz, input logic [31:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic legal(input int off, input int sz);
        return (sz == 1 || sz == 2 || sz == 4) && (off + sz <= 4);
    endfunction

    task automatic set_latch(input logic [31:0] v);
        access(1'b1, 16'hCF8, 3'd4, v);
        m_arm = v[31];
        m_idx = int'(v[7:2]);
    endtask

    task automatic win_write(input int off, input int sz, input logic [31:0] d);
        logic [63:0] m;
        access(1'b1, 16'hCFC + 16'(off), 3'(sz), d);
        if (m_arm && legal(off, sz)) begin
            m = ((64'h1 << (8 * sz)) - 64'h1) << (8 * off);
            model[m_idx] = (model[m_idx] & ~m[31:0]) | ((d << (8 * off)) & m[31:0]);
        end
    endtask

    function automatic logic [31:0] rd_expect(input int idx, input int off, input int sz);
        logic [31:0] v;
        v = model[idx] >> (8 * off);
        if (sz == 1) v = v & 32'hFF;
        else if (sz == 2) v = v & 32'hFFFF;
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        chk("R7 rd_valid in reset", {31'h0, rd_valid}, 32'h0);
        chk("R7 acc_err in reset", {31'h0, acc_err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 rd_valid after reset", {31'h0, rd_valid}, 32'h0);

        // R7 + R3: all registers zero, reads work with arm bit clear.
        for (int i = 0; i < 64; i++) begin
            set_latch(32'h0000_0000 | (32'(i) << 2));
            access(1'b0, 16'hCFC, 3'd4, '0);
            chk("R7 cleared register", rd_data, 32'h0);
        end

        // R3: write while disarmed is dropped.
        set_latch(32'h0000_0014);
        win_write(0, 4, 32'hDEAD_BEEF);
        access(1'b0, 16'hCFC, 3'd4, '0);
        chk("R3 disarmed write dropped", rd_data, 32'h0);

        // R1 R2 R4 R5: every register x offset x size code, junk latch bits.
        for (int i = 0; i < 64; i++) begin
            for (int off = 0; off < 4; off++) begin
                for (int sz = 0; sz < 8; sz++) begin
                    logic [31:0] d;
                    d = 32'hA5C3_5A3C ^ (32'(i) * 32'h0101_0101) ^ (32'(off) << 12) ^ (32'(sz) * 32'h1111);
                    set_latch(32'h8000_0000 | (32'(i) << 2) | (32'(i * 7 + 1) << 9) | 32'(off));
                    win_write(off, sz, d);
                    access(1'b0, 16'hCFC + 16'(i % 4), 3'd4, '0);
                    chk(legal(off, sz) ? "R4 lane merge" : "R5 illegal pair ignored",
                        rd_data, rd_expect(i, i % 4, 4));
                end
            end
        end

        // R3 R6 R8: read every register at each offset and size, latch disarmed.
        for (int i = 0; i < 64; i++) begin
            set_latch(32'h0000_0000 | (32'(i) << 2));
            for (int off = 0; off < 4; off++) begin
                for (int sz = 0; sz < 8; sz++) begin
                    access(1'b0, 16'hCFC + 16'(off), 3'(sz), '0);
                    chk("R6 shift and mask", rd_data, rd_expect(i, off, sz));
                    chk("R8 rd_valid after read", {31'h0, rd_valid}, 32'h1);
                    chk("R9 window no error", {31'h0, acc_err}, 32'h0);
                end
            end
        end

        // R8: no valid after a write or idle.
        set_latch(32'h8000_0008);
        chk("R8 no valid after write", {31'h0, rd_valid}, 32'h0);
        chk("R9 latch write no error", {31'h0, acc_err}, 32'h0);
        @(negedge clk);
        chk("R8 no valid when idle", {31'h0, rd_valid}, 32'h0);

        // R10: inputs without req_valid do nothing.
        req_write = 1'b1; req_addr = 16'hCFC; req_size = 3'd4; req_wdata = 32'h1234_5678;
        @(negedge clk);
        req_addr = 16'hCF8; req_wdata = 32'h8000_00FC;
        @(negedge clk);
        access(1'b0, 16'hCFC, 3'd4, '0);
        chk("R10 idle inputs ignored", rd_data, model[2]);

        // R9: undecoded locations and latch read.
        access(1'b0, 16'hCF8, 3'd4, '0);
        chk("R9 latch read data", rd_data, 32'hFFFF_FFFF);
        chk("R9 latch read error", {31'h0, acc_err}, 32'h1);
        access(1'b0, 16'h0CF4, 3'd1, '0);
        chk("R9 foreign read data", rd_data, 32'hFFFF_FFFF);
        chk("R9 foreign read error", {31'h0, acc_err}, 32'h1);
        access(1'b1, 16'h0080, 3'd1, 32'hFF);
        chk("R9 foreign write error", {31'h0, acc_err}, 32'h1);
        chk("R9 foreign write no valid", {31'h0, rd_valid}, 32'h0);
        access(1'b0, 16'hCFE, 3'd2, '0);
        chk("R9 error clears", {31'h0, acc_err}, 32'h0);
        chk("R2 index unchanged by foreign", rd_data, rd_expect(2, 2, 2));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule